// File: doc/BRIEF.md
# One-Time-Programmable Area Serial Program Engine

This block is the serial-side command engine for a small one-time-programmable (OTP) area inside a flash-style SPI slave. It watches SPI mode 0 traffic (active-low chip select, serial clock, data in, data out). It decodes four instructions: write enable, status read, OTP program and OTP read. The SPI pins are sampled by the system clock, so the serial clock must run several times slower than the system clock.

A program command gathers up to one area's worth of data bytes into a shadow buffer. The buffer is preset to all ones when the command begins. When chip select rises on a clean byte boundary, a self-timed busy cycle runs. At the end of that cycle every buffered byte is ANDed into the array, so programming can only clear bits.

The last byte of the area holds a lock bit in bit 0. Once that bit is cleared, the whole area is frozen for good. The array is held in registers that reset to all ones, which stands in for the erased state of real nonvolatile storage. The byte count `BYTES` must be a power of two, and the busy time `T_PP` is counted in system clock cycles.

Top module: `otp_prog_engine`

## Requirements
- R1: The program opcode 0x42 is followed by a 24-bit address and then one or more data bytes, all sent MSB first. Address bits above bit 5 are ignored, so the first data byte targets the byte selected by A5..A0.
- R2: The status opcode 0x05 returns bit 0 as write-in-progress and bit 1 as the write-enable latch, with all other bits 0. The byte repeats for as long as clocks continue, and this command also works during a busy cycle.
- R3: A program command changes the array only if the write-enable latch was set by a previous write-enable opcode 0x06.
- R4: A program cycle starts only when chip select rises exactly after the eighth bit of a data byte, with at least one data byte received. Any other ending leaves the array unchanged.
- R5: A program cycle can only clear bits: each target byte becomes its old value ANDed with the data byte received for it.
- R6: While bit 0 of the last byte (address 63) is 0, no program command changes the array.
- R7: During a busy cycle, write-enable, program and read opcodes are ignored, and the cycle in progress is not disturbed.
- R8: Write-in-progress reads 1 for T_PP system clocks from the accepted chip-select rise, then returns to 0. The write-enable latch is 0 when the cycle ends.
- R9: The read opcode 0x4B, followed by a 24-bit address and one dummy byte, streams array bytes MSB first on data out. The stream starts at A5..A0, and the address wraps from 63 back to 0.
- R10: Data byte addresses increment after each byte and wrap within the area. When more than 64 bytes are sent, later bytes replace the earlier buffered values rather than being ANDed with them.
- R11: A program command rejected for lock, a missing write enable or bad framing clears the write-enable latch and starts no busy cycle.
- R12: After reset, every array byte reads 0xFF and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The bench builds the block with the full 64-byte area, so address wrap, the lock byte and the 65-byte overflow case are all exercised at their real positions. It sets T_PP to 1500 clocks. With that value, a write-enable, a complete second program command and a status read all fit inside one busy cycle, which lets the busy-rejection path be tested. The same value still lets the bench wait out each cycle quickly.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  localparam logic [7:0] OP_WR_EN   = 8'h06;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_PROG    = 8'h42;
  localparam logic [7:0] OP_RD_OTP  = 8'h4B;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_PDATA, PH_STAT, PH_RDATA, PH_SKIP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrBuf;
    logic       setAddr;
    logic       wrBuf;
    logic       ldStatus;
    logic       ldOtp;
    logic       shiftOut;
    logic       commit;
    logic [7:0] rxByte;
    logic [7:0] statusByte;
  } otpStrobes_t;

endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_prog_pkg::*;
#(
  parameter int T_PP = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        mosi,
  input  logic        locked,
  output otpStrobes_t stb
);

  localparam int TW = $clog2(T_PP + 1);

  logic          sclkQ, csQ;
  logic          sclkRise, sclkFall, csRise, byteDone;
  phase_t        phase;
  logic [2:0]    bitCnt;
  logic [1:0]    addrIdx;
  logic          isProg, gotData, ldPend, ldKind;
  logic [6:0]    rxShift;
  logic [7:0]    rxNext;
  logic          welQ, busyQ;
  logic [TW-1:0] timer;
  logic          progEnd, progOk;

  assign sclkRise = !csN && sclk && !sclkQ;
  assign sclkFall = !csN && !sclk && sclkQ;
  assign csRise   = csN && !csQ;
  assign rxNext   = {rxShift, mosi};
  assign byteDone = sclkRise && (bitCnt == 3'd7);
  assign progEnd  = csRise && isProg && (phase == PH_ADDR || phase == PH_PDATA);
  assign progOk   = (phase == PH_PDATA) && (bitCnt == 3'd0) && gotData && welQ && !locked;

  always_comb begin
    stb            = '0;
    stb.rxByte     = rxNext;
    stb.statusByte = {6'b0, welQ, busyQ};
    if (byteDone) begin
      case (phase)
        PH_OPC:   stb.clrBuf  = (rxNext == OP_PROG) && !busyQ;
        PH_ADDR:  stb.setAddr = (addrIdx == 2'd2);
        PH_PDATA: stb.wrBuf   = 1'b1;
        default:  ;
      endcase
    end
    if (sclkFall) begin
      if (ldPend) begin
        stb.ldOtp    = ldKind;
        stb.ldStatus = !ldKind;
      end else begin
        stb.shiftOut = 1'b1;
      end
    end
    stb.commit = busyQ && (timer == TW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      csQ     <= 1'b1;
      phase   <= PH_OPC;
      bitCnt  <= '0;
      addrIdx <= '0;
      isProg  <= 1'b0;
      gotData <= 1'b0;
      ldPend  <= 1'b0;
      ldKind  <= 1'b0;
      rxShift <= '0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
      if (csN) begin
        phase   <= PH_OPC;
        bitCnt  <= '0;
        addrIdx <= '0;
        isProg  <= 1'b0;
        gotData <= 1'b0;
        ldPend  <= 1'b0;
      end else begin
        if (sclkFall && ldPend) ldPend <= 1'b0;
        if (sclkRise) begin
          rxShift <= rxNext[6:0];
          bitCnt  <= bitCnt + 3'd1;
        end
        if (byteDone) begin
          case (phase)
            PH_OPC: begin
              case (rxNext)
                OP_RD_STAT: begin phase <= PH_STAT; ldPend <= 1'b1; ldKind <= 1'b0; end
                OP_PROG:    begin phase <= busyQ ? PH_SKIP : PH_ADDR; isProg <= !busyQ; end
                OP_RD_OTP:  begin phase <= busyQ ? PH_SKIP : PH_ADDR; isProg <= 1'b0; end
                default:    phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              addrIdx <= addrIdx + 2'd1;
              if (addrIdx == 2'd2) phase <= isProg ? PH_PDATA : PH_DUMMY;
            end
            PH_DUMMY: begin phase <= PH_RDATA; ldPend <= 1'b1; ldKind <= 1'b1; end
            PH_PDATA: gotData <= 1'b1;
            PH_STAT:  begin ldPend <= 1'b1; ldKind <= 1'b0; end
            PH_RDATA: begin ldPend <= 1'b1; ldKind <= 1'b1; end
            default:  ;
          endcase
        end
      end
    end
  end

  // write-enable latch and self-timed busy cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      busyQ <= 1'b0;
      timer <= '0;
    end else if (busyQ) begin
      timer <= timer - TW'(1);
      if (timer == TW'(1)) begin
        busyQ <= 1'b0;
        welQ  <= 1'b0;
      end
    end else if (progEnd) begin
      if (progOk) begin
        busyQ <= 1'b1;
        timer <= TW'(T_PP);
      end else begin
        welQ <= 1'b0;
      end
    end else if (byteDone && phase == PH_OPC && rxNext == OP_WR_EN) begin
      welQ <= 1'b1;
    end
  end

  // R3: a busy cycle only begins with the latch set
  p_busy_needs_wel_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(welQ));

  // R4: a busy cycle only begins on a chip-select rise
  p_busy_on_cs_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(csRise));

  // R8: the latch is clear once the cycle ends
  p_wel_clear_at_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> !welQ);

endmodule

// File: rtl/otp_dpath.sv
module otp_dpath
  import otp_prog_pkg::*;
#(
  parameter int BYTES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  otpStrobes_t stb,
  output logic        miso,
  output logic        locked
);

  localparam int AW = $clog2(BYTES);

  logic [BYTES-1:0][7:0] mem;
  logic [BYTES-1:0][7:0] shadow;
  logic [AW-1:0]         addr;
  logic [7:0]            outShift;

  assign miso   = outShift[7];
  assign locked = !mem[BYTES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow   <= '1;
      addr     <= '0;
      outShift <= '0;
    end else begin
      if (stb.clrBuf)   shadow <= '1;
      if (stb.setAddr)  addr <= stb.rxByte[AW-1:0];
      if (stb.wrBuf) begin
        shadow[addr] <= stb.rxByte;
        addr         <= addr + AW'(1);
      end
      if (stb.ldOtp) begin
        outShift <= mem[addr];
        addr     <= addr + AW'(1);
      end
      if (stb.ldStatus) outShift <= stb.statusByte;
      if (stb.shiftOut) outShift <= {outShift[6:0], 1'b0};
    end
  end

  // one merge register per byte
  for (genvar i = 0; i < BYTES; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           mem[i] <= 8'hFF;
      else if (stb.commit) mem[i] <= mem[i] & shadow[i];
    end
  end

  // R5: no array bit ever goes from 0 to 1
  p_only_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mem & ~$past(mem)) == '0);

  // R6: a locked array never changes
  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(mem));

endmodule

// File: rtl/otp_prog_engine.sv
module otp_prog_engine
  import otp_prog_pkg::*;
#(
  parameter int BYTES = 64,
  parameter int T_PP  = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  output logic miso
);

  otpStrobes_t stb;
  logic        locked;

  otp_ctrl #(.T_PP(T_PP)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .locked(locked), .stb(stb)
  );

  otp_dpath #(.BYTES(BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .miso(miso), .locked(locked)
  );

endmodule

// File: tb/otp_prog_engine_tb.sv
module otp_prog_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int T_PP       = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int errors = 0;
  logic [7:0] dataBuf [0:127];
  logic [7:0] rdBuf   [0:127];

  always #(CLK_PERIOD / 2) clk = !clk;

  otp_prog_engine #(.BYTES(64), .T_PP(T_PP)) u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int b = 0; b < nbits; b++) begin
      mosi = tx[7-b];
      waitClk(HALF);
      sclk = 1'b1;
      rx = {rx[6:0], miso};
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] tx);
    logic [7:0] rx;
    xferBits(tx, 8, rx);
  endtask

  task automatic csStart();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csEnd();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic wren();
    csStart(); sendByte(8'h06); csEnd();
  endtask

  task automatic readStatus(output logic [7:0] s);
    logic [7:0] rx;
    csStart(); sendByte(8'h05); xferBits(8'h00, 8, rx); csEnd();
    s = rx;
  endtask

  task automatic progCmd(input logic [23:0] a, input int n, input int extraBits);
    logic [7:0] rx;
    csStart();
    sendByte(8'h42);
    sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]);
    for (int i = 0; i < n; i++) sendByte(dataBuf[i]);
    if (extraBits > 0) xferBits(8'h00, extraBits, rx);
    csEnd();
  endtask

  task automatic readOtp(input logic [23:0] a, input int n);
    logic [7:0] rx;
    csStart();
    sendByte(8'h4B);
    sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]);
    sendByte(8'h00);
    for (int i = 0; i < n; i++) begin
      xferBits(8'h00, 8, rx);
      rdBuf[i] = rx;
    end
    csEnd();
  endtask

  task automatic readOne(input logic [5:0] a, output logic [7:0] v);
    readOtp({18'h0, a}, 1);
    v = rdBuf[0];
  endtask

  task automatic waitIdle();
    waitClk(T_PP + 20);
  endtask

  task automatic testReset();
    logic [7:0] s;
    readStatus(s);
    check("R12 status after reset", s, 8'h00);
    readOtp(24'h0, 4);
    for (int i = 0; i < 4; i++) check("R12 array erased", rdBuf[i], 8'hFF);
  endtask

  task automatic testNoWren();
    logic [7:0] s, v;
    dataBuf[0] = 8'h00;
    progCmd(24'h000002, 1, 0);
    readStatus(s);
    check("R3 no busy without latch", s, 8'h00);
    readOne(6'd2, v);
    check("R3 array unchanged", v, 8'hFF);
  endtask

  task automatic testBasicProgram();
    logic [7:0] s, v;
    wren();
    readStatus(s);
    check("R2 latch shown in bit 1", s, 8'h02);
    dataBuf[0] = 8'hF0; dataBuf[1] = 8'h3C;
    progCmd(24'hABCD05, 2, 0);
    readStatus(s);
    check("R8 busy with latch", s, 8'h03);
    waitIdle();
    readStatus(s);
    check("R8 idle after cycle, latch clear", s, 8'h00);
    readOtp(24'h000005, 2);
    check("R1 first byte at A5..A0", rdBuf[0], 8'hF0);
    check("R1 second byte", rdBuf[1], 8'h3C);
    readOne(6'd4, v);
    check("R1 neighbour untouched", v, 8'hFF);
  endtask

  task automatic testAndOnly();
    logic [7:0] v;
    wren();
    dataBuf[0] = 8'h0F; dataBuf[1] = 8'hFF;
    progCmd(24'h000005, 2, 0);
    waitIdle();
    readOne(6'd5, v);
    check("R5 AND clears", v, 8'h00);
    readOne(6'd6, v);
    check("R5 ones keep old value", v, 8'h3C);
  endtask

  task automatic testFraming();
    logic [7:0] s, v;
    wren();
    dataBuf[0] = 8'h00;
    progCmd(24'h000028, 1, 4);
    readStatus(s);
    check("R11 mid-byte end clears latch, no busy", s, 8'h00);
    readOne(6'd40, v);
    check("R4 mid-byte end no program", v, 8'hFF);
    wren();
    progCmd(24'h000028, 0, 0);
    readStatus(s);
    check("R4 no data byte no busy", s, 8'h00);
    readOne(6'd40, v);
    check("R4 no data byte unchanged", v, 8'hFF);
  endtask

  task automatic testWrap();
    wren();
    dataBuf[0] = 8'hAA; dataBuf[1] = 8'hF1; dataBuf[2] = 8'h55;
    progCmd(24'h00003E, 3, 0);
    waitIdle();
    readOtp(24'h00003E, 3);
    check("R9 read byte 62", rdBuf[0], 8'hAA);
    check("R9 read byte 63", rdBuf[1], 8'hF1);
    check("R10 write wrapped to byte 0", rdBuf[2], 8'h55);
  endtask

  task automatic testOverflow();
    logic [7:0] v;
    for (int i = 0; i < 65; i++) dataBuf[i] = 8'hFF;
    dataBuf[0]  = 8'h00;
    dataBuf[64] = 8'h7E;
    wren();
    progCmd(24'h00000A, 65, 0);
    waitIdle();
    readOne(6'd10, v);
    check("R10 later byte replaces buffered", v, 8'h7E);
    readOne(6'd11, v);
    check("R10 other bytes untouched", v, 8'hFF);
  endtask

  task automatic testBusyReject();
    logic [7:0] s, v;
    wren();
    dataBuf[0] = 8'hF0;
    progCmd(24'h00001E, 1, 0);
    wren();
    dataBuf[0] = 8'h00;
    progCmd(24'h00001F, 1, 0);
    readStatus(s);
    check("R7 status during busy", s, 8'h03);
    waitIdle();
    readStatus(s);
    check("R7 latch clear after cycle", s, 8'h00);
    readOne(6'd30, v);
    check("R7 first program landed", v, 8'hF0);
    readOne(6'd31, v);
    check("R7 busy program ignored", v, 8'hFF);
  endtask

  task automatic testLock();
    logic [7:0] s, v;
    wren();
    dataBuf[0] = 8'hFE;
    progCmd(24'h00003F, 1, 0);
    waitIdle();
    readOne(6'd63, v);
    check("R6 lock byte programmed", v, 8'hF0);
    wren();
    dataBuf[0] = 8'h00;
    progCmd(24'h000014, 1, 0);
    readStatus(s);
    check("R11 locked reject clears latch", s, 8'h00);
    readOne(6'd20, v);
    check("R6 locked array unchanged", v, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testNoWren();
    testBasicProgram();
    testAndOnly();
    testFraming();
    testWrap();
    testOverflow();
    testBusyReject();
    testLock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule